// File: doc/BRIEF.md
# Video configuration register and palette slave

This block is the host-facing configuration slave of a framebuffer display controller. A 32-bit Wishbone classic slave port lets a processor program the display timing, the framebuffer base address, the pixel format and sync polarities, and load a two-bank colour palette. The decoded configuration fields leave the block as plain outputs that feed the timing generator and the pixel pipeline. Neither of those is part of this block.

Address bit 11 selects the target. When it is low, a small register file is addressed by address bits 7..2. When it is high, the palette RAM is addressed. The palette holds 512 entries of 24 bits. The host reaches only the 256-entry half chosen by the bank-select bit of the control register. The video fetch master reports through a busy flag when it is reading memory. While that flag is high, writes to the control register are acknowledged but dropped, so the pixel format and bank cannot change in the middle of a fetch.

Top module: `vid_cfg_slave`

## Requirements
- R1: After reset, every configuration output is zero, ack_o is low, and every register index reads back zero.
- R2: A request is strobe and cycle both high at a rising edge. ack_o goes high for exactly one cycle, in the cycle after the request is sampled. It is never high in two consecutive cycles.
- R3: With address bit 11 low, address bits 7..2 select the register. Index 2 is horizontal timing, 3 is vertical timing and 4 is display lengths. Each of these stores and reads back all 32 bits, and drives its value on htim_o, vtim_o and hvlen_o.
- R4: Index 0 is the control word. It stores all 32 bits and reads them back. Its bits drive the control outputs as follows: bit 0 vid_en_o, bit 4 bank_sel_o, bits 6:5 bit_mode_o (00 = 8, 01 = 4, 10 = 2, 11 = 1 bit per pixel), bit 7 idx_color_o, bits 8 to 11 hs_pol_o, vs_pol_o, cs_pol_o and blank_pol_o (1 = active low), and bit 12 clkdiv_en_o.
- R5: A control write made while fetch_busy_i is high is acknowledged, but it leaves the control word and the control outputs unchanged.
- R6: Index 5 stores write bits 31..2 on base_adr_o. It reads back with bits 1..0 zero.
- R7: Index 6 (clock divisor) and index 7 (palette offset) store write bits 7..0. They read back zero-extended to 32 bits.
- R8: Index 1 is read-only status. It reads the current bank-select bit in bit 4 and zero in every other bit. Writes to it have no effect.
- R9: With address bit 11 high, the palette entry is selected by {bank_sel, address bits 9..2}. A write stores data bits 23..0. A read returns that value with bits 31..24 zero.
- R10: Register indices 8 to 63 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adr_i | input | 12 | Byte address from the host |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid while ack_o is high |
| sel_i | input | 4 | Byte select; every write is treated as a full word |
| we_i | input | 1 | 1 = write, 0 = read |
| stb_i | input | 1 | Strobe |
| cyc_i | input | 1 | Bus cycle |
| ack_o | output | 1 | Transfer acknowledge |
| fetch_busy_i | input | 1 | Video fetch master is reading memory |
| vid_en_o | output | 1 | Video enable |
| bank_sel_o | output | 1 | Active palette bank |
| bit_mode_o | output | 2 | Bits-per-pixel code |
| idx_color_o | output | 1 | Indexed-colour enable |
| hs_pol_o | output | 1 | Hsync active low |
| vs_pol_o | output | 1 | Vsync active low |
| cs_pol_o | output | 1 | Composite sync active low |
| blank_pol_o | output | 1 | Blank active low |
| clkdiv_en_o | output | 1 | Clock-divide enable |
| htim_o | output | 32 | Horizontal timing word |
| vtim_o | output | 32 | Vertical timing word |
| hvlen_o | output | 32 | Display length word |
| base_adr_o | output | 30 | Framebuffer word address |
| clk_div_o | output | 8 | Clock divisor reload |
| pal_ofs_o | output | 8 | Palette offset |

## Verification
Two functions can meet in the same clock edge. One is a control write that flips the bank-select bit. The other is the fetch-busy refusal of that write. The bench holds fetch_busy_i high across a control write that tries to change banks. It then judges the outcome at the ports: the status bit and the bank_sel_o output must keep the old bank, and a palette read made afterwards must return the entry written earlier into the old bank. The same write is then repeated with busy low, and it must switch the bank and expose the other bank's entries.

// File: rtl/vid_cfg_pkg.sv
package vid_cfg_pkg;
  localparam int ADR_W = 12;
  localparam int DAT_W = 32;
  localparam int IDX_W = 6;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 6'd0;
  localparam logic [IDX_W-1:0] IDX_STAT  = 6'd1;
  localparam logic [IDX_W-1:0] IDX_HTIM  = 6'd2;
  localparam logic [IDX_W-1:0] IDX_VTIM  = 6'd3;
  localparam logic [IDX_W-1:0] IDX_HVLEN = 6'd4;
  localparam logic [IDX_W-1:0] IDX_BASE  = 6'd5;
  localparam logic [IDX_W-1:0] IDX_CDIV  = 6'd6;
  localparam logic [IDX_W-1:0] IDX_POFS  = 6'd7;

  typedef struct packed {
    logic [18:0] rsvd_hi;
    logic        clkdiv_en;
    logic        blank_pol;
    logic        cs_pol;
    logic        vs_pol;
    logic        hs_pol;
    logic        idx_color;
    logic [1:0]  bit_mode;
    logic        bank_sel;
    logic [2:0]  rsvd_lo;
    logic        vid_en;
  } ctrl_t;
endpackage

// File: rtl/vid_bus_ack.sv
module vid_bus_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic cyc_i,
  output logic req_o,
  output logic ack_o
);
  logic ack_q;

  // a request edge is one where no ack is already out
  assign req_o = stb_i & cyc_i & ~ack_q;
  assign ack_o = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_o;
  end
endmodule

// File: rtl/vid_cfg_regs.sv
module vid_cfg_regs
  import vid_cfg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IW   = 6,
  parameter int SMLW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdat_i,
  input  logic          busy_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] htim_o,
  output logic [DW-1:0] vtim_o,
  output logic [DW-1:0] hvlen_o,
  output logic [DW-3:0] base_o,
  output logic [SMLW-1:0] cdiv_o,
  output logic [SMLW-1:0] pofs_o,
  output logic [DW-1:0] rdat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      htim_o  <= '0;
      vtim_o  <= '0;
      hvlen_o <= '0;
      base_o  <= '0;
      cdiv_o  <= '0;
      pofs_o  <= '0;
    end else if (wr_i) begin
      case (idx_i)
        IDX_CTRL:  if (!busy_i) ctrl_o <= ctrl_t'(wdat_i);
        IDX_HTIM:  htim_o  <= wdat_i;
        IDX_VTIM:  vtim_o  <= wdat_i;
        IDX_HVLEN: hvlen_o <= wdat_i;
        IDX_BASE:  base_o  <= wdat_i[DW-1:2];
        IDX_CDIV:  cdiv_o  <= wdat_i[SMLW-1:0];
        IDX_POFS:  pofs_o  <= wdat_i[SMLW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdat_o = '0;
    case (idx_i)
      IDX_CTRL:  rdat_o = ctrl_o;
      IDX_STAT:  rdat_o[4] = ctrl_o.bank_sel;
      IDX_HTIM:  rdat_o = htim_o;
      IDX_VTIM:  rdat_o = vtim_o;
      IDX_HVLEN: rdat_o = hvlen_o;
      IDX_BASE:  rdat_o = {base_o, 2'b00};
      IDX_CDIV:  rdat_o[SMLW-1:0] = cdiv_o;
      IDX_POFS:  rdat_o[SMLW-1:0] = pofs_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/vid_palette.sv
module vid_palette #(
  parameter int AW = 9,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdat_i,
  output logic [DW-1:0] rdat_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdat_i;
    if (re_i) rdat_o <= mem[addr_i];
  end
endmodule

// File: rtl/vid_cfg_slave.sv
module vid_cfg_slave
  import vid_cfg_pkg::*;
#(
  parameter int BANK_AW = 8,
  parameter int PAL_W   = 24,
  parameter int SMLW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [DAT_W-1:0]  dat_i,
  output logic [DAT_W-1:0]  dat_o,
  input  logic [3:0]        sel_i,
  input  logic              we_i,
  input  logic              stb_i,
  input  logic              cyc_i,
  output logic              ack_o,
  input  logic              fetch_busy_i,
  output logic              vid_en_o,
  output logic              bank_sel_o,
  output logic [1:0]        bit_mode_o,
  output logic              idx_color_o,
  output logic              hs_pol_o,
  output logic              vs_pol_o,
  output logic              cs_pol_o,
  output logic              blank_pol_o,
  output logic              clkdiv_en_o,
  output logic [DAT_W-1:0]  htim_o,
  output logic [DAT_W-1:0]  vtim_o,
  output logic [DAT_W-1:0]  hvlen_o,
  output logic [DAT_W-3:0]  base_adr_o,
  output logic [SMLW-1:0]   clk_div_o,
  output logic [SMLW-1:0]   pal_ofs_o
);
  localparam int PAL_AW = BANK_AW + 1;
  localparam int SEL_BIT = ADR_W - 1;

  logic               req;
  logic               reg_wr, pal_wr, pal_rd;
  ctrl_t              ctrl;
  logic [DAT_W-1:0]   reg_rdat, reg_rd_q;
  logic [PAL_W-1:0]   pal_rdat;
  logic [PAL_AW-1:0]  pal_addr;
  logic               sel_pal_q;
  logic               unused_bits;

  // byte lanes and the spare address bits carry no meaning here
  assign unused_bits = ^{sel_i, adr_i[SEL_BIT-1], adr_i[1:0]};

  vid_bus_ack i_ack (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(stb_i), .cyc_i(cyc_i),
    .req_o (req),   .ack_o (ack_o)
  );

  assign reg_wr = req &  we_i & ~adr_i[SEL_BIT];
  assign pal_wr = req &  we_i &  adr_i[SEL_BIT];
  assign pal_rd = req & ~we_i &  adr_i[SEL_BIT];

  vid_cfg_regs #(.DW(DAT_W), .IW(IDX_W), .SMLW(SMLW)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr),
    .idx_i  (adr_i[IDX_W+1:2]),
    .wdat_i (dat_i),
    .busy_i (fetch_busy_i),
    .ctrl_o (ctrl),
    .htim_o (htim_o),
    .vtim_o (vtim_o),
    .hvlen_o(hvlen_o),
    .base_o (base_adr_o),
    .cdiv_o (clk_div_o),
    .pofs_o (pal_ofs_o),
    .rdat_o (reg_rdat)
  );

  // host sees only the bank chosen by the control word
  assign pal_addr = {ctrl.bank_sel, adr_i[BANK_AW+1:2]};

  vid_palette #(.AW(PAL_AW), .DW(PAL_W)) i_pal (
    .clk_i (clk_i),
    .we_i  (pal_wr),
    .re_i  (pal_rd),
    .addr_i(pal_addr),
    .wdat_i(dat_i[PAL_W-1:0]),
    .rdat_o(pal_rdat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rd_q  <= '0;
      sel_pal_q <= 1'b0;
    end else if (req) begin
      reg_rd_q  <= reg_rdat;
      sel_pal_q <= adr_i[SEL_BIT];
    end
  end

  assign dat_o = sel_pal_q ? {{(DAT_W-PAL_W){1'b0}}, pal_rdat} : reg_rd_q;

  assign vid_en_o    = ctrl.vid_en;
  assign bank_sel_o  = ctrl.bank_sel;
  assign bit_mode_o  = ctrl.bit_mode;
  assign idx_color_o = ctrl.idx_color;
  assign hs_pol_o    = ctrl.hs_pol;
  assign vs_pol_o    = ctrl.vs_pol;
  assign cs_pol_o    = ctrl.cs_pol;
  assign blank_pol_o = ctrl.blank_pol;
  assign clkdiv_en_o = ctrl.clkdiv_en;
endmodule

// File: rtl/vid_cfg_slave_chk.sv
module vid_cfg_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] adr_i,
  input logic        we_i,
  input logic        stb_i,
  input logic        cyc_i,
  input logic        ack_o,
  input logic [31:0] dat_o,
  input logic        fetch_busy_i,
  input logic        vid_en_o,
  input logic        bank_sel_o,
  input logic [1:0]  bit_mode_o,
  input logic        idx_color_o,
  input logic        hs_pol_o,
  input logic        vs_pol_o,
  input logic        cs_pol_o,
  input logic        blank_pol_o,
  input logic        clkdiv_en_o
);
  logic [9:0] ctrl_vis;
  assign ctrl_vis = {vid_en_o, bank_sel_o, bit_mode_o, idx_color_o,
                     hs_pol_o, vs_pol_o, cs_pol_o, blank_pol_o, clkdiv_en_o};

  assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(stb_i && cyc_i));

  assert_busy_holds_ctrl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_busy_i |=> $stable(ctrl_vis));

  assert_status_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(!we_i && !adr_i[11] && adr_i[7:2] == 6'd1))
      |-> (dat_o[31:5] == '0 && dat_o[3:0] == '0 && dat_o[4] == bank_sel_o));

  assert_base_lsb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(!we_i && !adr_i[11] && adr_i[7:2] == 6'd5)) |-> dat_o[1:0] == 2'b00);

  assert_pal_top_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(!we_i && adr_i[11])) |-> dat_o[31:24] == 8'h00);

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(!we_i && !adr_i[11] && adr_i[7:2] > 6'd7)) |-> dat_o == '0);
endmodule

bind vid_cfg_slave vid_cfg_slave_chk i_chk (.*);

// File: tb/test_vid_cfg_slave.sv
module test_vid_cfg_slave;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] adr_i = '0;
  logic [31:0] dat_i = '0;
  logic [31:0] dat_o;
  logic [3:0]  sel_i = 4'hF;
  logic        we_i = 1'b0, stb_i = 1'b0, cyc_i = 1'b0;
  logic        ack_o;
  logic        fetch_busy_i = 1'b0;
  logic        vid_en_o, bank_sel_o, idx_color_o, hs_pol_o, vs_pol_o, cs_pol_o;
  logic        blank_pol_o, clkdiv_en_o;
  logic [1:0]  bit_mode_o;
  logic [31:0] htim_o, vtim_o, hvlen_o;
  logic [29:0] base_adr_o;
  logic [7:0]  clk_div_o, pal_ofs_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_htim, m_vtim, m_hvlen;
  logic [29:0] m_base;
  logic [7:0]  m_cdiv, m_pofs;

  vid_cfg_slave i_vid_cfg_slave (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  // one full transfer: request sampled at the next edge, ack seen one cycle later
  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    @(negedge clk_i);
    we_i = w; adr_i = a; dat_i = d; stb_i = 1'b1; cyc_i = 1'b1;
    @(negedge clk_i);
    chk("R2 ack after request", {31'b0, ack_o}, 32'd1);
    q = dat_o;
    stb_i = 1'b0; cyc_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
    chk("R2 ack single cycle", {31'b0, ack_o}, 32'd0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    xfer(1'b0, a, 32'h0, q);
  endtask

  function automatic logic [31:0] exp_reg(input int idx);
    case (idx)
      0: return m_ctrl;
      1: return {27'b0, m_ctrl[4], 4'b0};
      2: return m_htim;
      3: return m_vtim;
      4: return m_hvlen;
      5: return {m_base, 2'b00};
      6: return {24'b0, m_cdiv};
      7: return {24'b0, m_pofs};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (32'(i) << 7);
  endfunction

  function automatic logic [23:0] pal_val(input int bank, input int i);
    return 24'((i * 24'h010203) ^ (bank ? 24'hA5_5A_C3 : 24'h3C_0F_11));
  endfunction

  task automatic model_wr(input int idx, input logic [31:0] d);
    case (idx)
      0: if (!fetch_busy_i) m_ctrl = d;
      2: m_htim = d;
      3: m_vtim = d;
      4: m_hvlen = d;
      5: m_base = d[31:2];
      6: m_cdiv = d[7:0];
      7: m_pofs = d[7:0];
      default: ;
    endcase
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] d);
    wr(12'(idx << 2), d);
    model_wr(idx, d);
  endtask

  task automatic chk_ctrl_out(input string req);
    chk(req, {22'b0, clkdiv_en_o, blank_pol_o, cs_pol_o, vs_pol_o, hs_pol_o,
              idx_color_o, bit_mode_o, bank_sel_o, 3'b0, vid_en_o},
        {19'b0, m_ctrl[12:4], 3'b0, m_ctrl[0]});
  endtask

  task automatic chk_all_regs(input string req);
    logic [31:0] q;
    for (int idx = 0; idx < 8; idx++) begin
      rd(12'(idx << 2), q);
      chk(req, q, exp_reg(idx));
    end
    chk(req, htim_o, m_htim);
    chk(req, vtim_o, m_vtim);
    chk(req, hvlen_o, m_hvlen);
    chk(req, {2'b0, base_adr_o}, {2'b0, m_base});
    chk(req, {16'b0, clk_div_o, pal_ofs_o}, {16'b0, m_cdiv, m_pofs});
    chk_ctrl_out(req);
  endtask

  initial begin
    logic [31:0] q;
    m_ctrl = '0; m_htim = '0; m_vtim = '0; m_hvlen = '0;
    m_base = '0; m_cdiv = '0; m_pofs = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 ack in reset", {31'b0, ack_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ack after reset", {31'b0, ack_o}, 32'd0);
    chk_all_regs("R1 reset state");

    // R3 R6 R7: timing, base, divisor and offset registers across patterns
    for (int k = 0; k < 16; k++) begin
      for (int idx = 2; idx < 8; idx++) reg_wr(idx, pat(k * 8 + idx));
      chk_all_regs("R3 R6 R7 register sweep");
    end

    // R4: control field decode and readback, R8 status follows bank
    for (int v = 0; v < 1024; v++) begin
      logic [31:0] d;
      d = {pat(v)[31:13], v[9:0] ^ pat(v)[12:10] << 10 ^ 13'(v * 7)};
      reg_wr(0, d);
      chk_ctrl_out("R4 control outputs");
      rd(12'h000, q);
      chk("R4 control readback", q, m_ctrl);
      rd(12'h004, q);
      chk("R8 status bank bit", q, {27'b0, m_ctrl[4], 4'b0});
    end

    // R5: busy refuses control writes but still acknowledges them
    for (int k = 0; k < 8; k++) begin
      reg_wr(0, pat(k + 100));
      fetch_busy_i = 1'b1;
      reg_wr(0, ~pat(k + 100));
      chk_ctrl_out("R5 busy ignored");
      rd(12'h000, q);
      chk("R5 busy ignored readback", q, m_ctrl);
      fetch_busy_i = 1'b0;
      reg_wr(0, ~pat(k + 100));
      chk_ctrl_out("R5 write after busy");
    end

    // R8: writes to status have no effect
    reg_wr(0, 32'h0000_0010);
    wr(12'h004, 32'hFFFF_FFFF);
    chk_all_regs("R8 status write ignored");

    // R10: unmapped indices
    for (int idx = 8; idx < 64; idx++) begin
      wr(12'(idx << 2), 32'hFFFF_FFFF);
      rd(12'(idx << 2), q);
      chk("R10 unmapped reads zero", q, 32'h0);
    end
    chk_all_regs("R10 unmapped writes ignored");

    // R9: fill both banks, read back each through bank select
    for (int b = 0; b < 2; b++) begin
      reg_wr(0, 32'(b) << 4);
      for (int i = 0; i < 256; i++) wr(12'h800 | 12'(i << 2), {8'hEE, pal_val(b, i)});
    end
    for (int b = 0; b < 2; b++) begin
      reg_wr(0, 32'(b) << 4);
      for (int i = 0; i < 256; i++) begin
        rd(12'h800 | 12'(i << 2), q);
        chk("R9 palette readback", q, {8'h00, pal_val(b, i)});
      end
    end

    // R5 with R9: bank flip refused while busy keeps palette on old bank
    reg_wr(0, 32'h0);
    fetch_busy_i = 1'b1;
    reg_wr(0, 32'h10);
    fetch_busy_i = 1'b0;
    chk("R5 bank held", {31'b0, bank_sel_o}, 32'd0);
    rd(12'h800 | 12'(37 << 2), q);
    chk("R5 R9 old bank entry", q, {8'h00, pal_val(0, 37)});
    reg_wr(0, 32'h10);
    rd(12'h004, q);
    chk("R8 status after flip", q, 32'h10);
    rd(12'h800 | 12'(37 << 2), q);
    chk("R9 new bank entry", q, {8'h00, pal_val(1, 37)});

    finish_run();
  end
endmodule